// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a bitstream into an FPGA through its passive serial configuration port. A start strobe opens the sequence. The block pulls the configuration-request line low for a fixed time and confirms that the device drops its status line in answer. It then releases the request and waits, within a timeout, for the status line to rise again.

Once the device is ready, the block takes configuration bytes from a valid/ready stream. It shifts each byte out least-significant bit first on a data pin, under a serial clock that it generates from the system clock. The byte flagged as last ends the data phase. The block then checks that the device reports configuration complete and sends twelve extra serial clock pulses to finish initialisation.

The outcome is held on a done flag or on an error flag with a code until the next start. Time intervals are given in microseconds and converted to system clocks through a clock frequency parameter. The serial clock half-period is a whole number of system clocks.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, cfg_n is high, dclk is low, in_ready is low, and both cfg_done and cfg_err are low.
- R2: A start pulse while idle drives cfg_n low for at least CFG_US microseconds, counted as CLK_HZ/1e6*CFG_US system clocks.
- R3: If the synchronised status_n is still high when the cfg_n low time ends, the block aborts with err_code 1.
- R4: After cfg_n is released, the block waits CFG_US microseconds and then polls status_n for a high level. If no high level is seen within TIMEOUT_US microseconds, it aborts with err_code 2, and the error appears no earlier than that timeout after the release.
- R5: Each byte is sent least-significant bit first, 8 bits per byte. data0 is stable on every rising edge of dclk and throughout its high phase.
- R6: Every high phase and every low phase of dclk lasts at least DCLK_HALF system clocks.
- R7: in_ready is high only while dclk is low and the previous byte has been fully shifted. Exactly one byte is taken per handshake. The byte that carries in_last ends the data phase, and in_ready stays low after it.
- R8: If conf_done reads low after the last bit, the block aborts with err_code 3, and no further dclk pulses follow.
- R9: With conf_done high, exactly 12 further dclk rising edges are generated, after which cfg_done goes high with cfg_err low.
- R10: On any abort, cfg_n is high and dclk is low. cfg_err and err_code, or cfg_done, hold their values until the next start, and the next start clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin configuration |
| in_valid | input | 1 | Byte on in_data is valid |
| in_data | input | 8 | Configuration byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Block accepts a byte this cycle |
| cfg_n | output | 1 | Configuration request to the device, active low |
| dclk | output | 1 | Serial configuration clock |
| data0 | output | 1 | Serial configuration data |
| status_n | input | 1 | Device status line, asynchronous |
| conf_done | input | 1 | Device configuration-complete line, asynchronous |
| cfg_done | output | 1 | Configuration finished successfully |
| cfg_err | output | 1 | Configuration aborted |
| err_code | output | 2 | 1 status stuck high, 2 status timeout, 3 conf_done missing |

## Verification
The bench runs a device model that answers cfg_n with status_n after set delays and raises conf_done once it has counted the expected number of rising edges. Against this model it checks the following:
- The bit order is recovered at each rising edge. A design that sent the most-significant bit first, or that changed data0 while dclk was high, would deliver a wrong bit stream.
- Every dclk phase is measured. A divider with an off-by-one error would show a phase shorter than DCLK_HALF.
- The trailing edges are counted. A design that sent 11 or 13 of them would miss R9.
- The three abort paths are forced one after the other. A design that confused them would report a wrong err_code. A design that timed out too early would raise the error before the timeout had run. A design that left dclk running after a missing conf_done would show trailing edges.

// File: rtl/ps_cfg_master.sv
module ps_cfg_master #(
  parameter int CLK_HZ       = 250_000_000,
  parameter int CFG_US       = 2,
  parameter int TIMEOUT_US   = 100_000,
  parameter int DCLK_HALF    = 3,
  parameter int TRAIL_PULSES = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       cfg_n,
  output logic       dclk,
  output logic       data0,
  input  logic       status_n,
  input  logic       conf_done,
  output logic       cfg_done,
  output logic       cfg_err,
  output logic [1:0] err_code
);
  localparam int TCFG = CLK_HZ / 1_000_000 * CFG_US;
  localparam int TOUT = CLK_HZ / 1_000_000 * TIMEOUT_US;
  localparam int CW   = $clog2(TOUT + TCFG + 1);
  localparam int DW   = $clog2(DCLK_HALF + 1);
  localparam int PW   = $clog2(TRAIL_PULSES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CLOW, S_REL, S_POLL, S_LOAD, S_SHIFT, S_CHK, S_TRAIL} st_t;
  st_t st;

  logic [1:0]    ns_sync, cd_sync;
  logic [CW-1:0] cnt;
  logic [DW-1:0] div;
  logic [PW-1:0] pulses;
  logic [7:0]    sh;
  logic [2:0]    bits;
  logic          last_q;

  wire nst     = ns_sync[1];
  wire cdone   = cd_sync[1];
  wire clocked = (st == S_SHIFT) || (st == S_TRAIL);
  wire tick    = clocked && (div == DW'(DCLK_HALF - 1));

  assign in_ready = (st == S_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_sync <= 2'b11;
      cd_sync <= 2'b00;
    end else begin
      ns_sync <= {ns_sync[0], status_n};
      cd_sync <= {cd_sync[0], conf_done};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cfg_n <= 1'b1; dclk <= 1'b0; data0 <= 1'b0;
      cfg_done <= 1'b0; cfg_err <= 1'b0; err_code <= 2'd0;
      cnt <= '0; div <= '0; pulses <= '0; sh <= '0; bits <= '0; last_q <= 1'b0;
    end else begin
      div <= (tick || !clocked) ? '0 : div + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          cfg_n <= 1'b0; cnt <= '0; cfg_done <= 1'b0; cfg_err <= 1'b0; err_code <= 2'd0;
          st <= S_CLOW;
        end
        S_CLOW: if (cnt == CW'(TCFG - 1)) begin
          cnt <= '0;
          cfg_n <= 1'b1;
          if (nst) begin
            cfg_err <= 1'b1; err_code <= 2'd1; st <= S_IDLE;
          end else st <= S_REL;
        end else cnt <= cnt + 1'b1;
        S_REL: if (cnt == CW'(TCFG - 1)) begin
          cnt <= '0; st <= S_POLL;
        end else cnt <= cnt + 1'b1;
        S_POLL: if (nst) st <= S_LOAD;
        else if (cnt == CW'(TOUT - 1)) begin
          cfg_err <= 1'b1; err_code <= 2'd2; st <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_LOAD: if (in_valid) begin
          sh <= in_data; data0 <= in_data[0]; last_q <= in_last; bits <= '0; div <= '0;
          st <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!dclk) dclk <= 1'b1;
          else begin
            dclk <= 1'b0;
            if (bits == 3'd7) st <= last_q ? S_CHK : S_LOAD;
            else begin
              bits <= bits + 1'b1; sh <= sh >> 1; data0 <= sh[1];
            end
          end
        end
        S_CHK: if (cdone) begin
          pulses <= '0; div <= '0; st <= S_TRAIL;
        end else begin
          cfg_err <= 1'b1; err_code <= 2'd3; st <= S_IDLE;
        end
        S_TRAIL: if (tick) begin
          if (!dclk) dclk <= 1'b1;
          else begin
            dclk <= 1'b0;
            if (pulses == PW'(TRAIL_PULSES - 1)) begin
              cfg_done <= 1'b1; st <= S_IDLE;
            end else pulses <= pulses + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_abort_safe_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (cfg_n && !dclk));
  assert_ready_low_clk_R7: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !dclk);
  assert_data_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (dclk && $past(dclk)) |-> $stable(data0));
  assert_outcome_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(cfg_done && cfg_err));
  assert_code_valid_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (err_code != 2'd0));
  assert_clk_idle_at_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> (cfg_n && !dclk));
endmodule

// File: tb/ps_cfg_master_tb.sv
module ps_cfg_master_tb;
  localparam int DIV  = 3;
  localparam int TCFG = 500;
  localparam int TOUT = 5000;

  logic clk = 0, rst = 1, start = 0, in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, cfg_n, dclk, data0, cfg_done, cfg_err;
  logic [1:0] err_code;
  logic status_n = 1, conf_done = 0;

  ps_cfg_master #(.CLK_HZ(250_000_000), .CFG_US(2), .TIMEOUT_US(20), .DCLK_HALF(DIV)) u_dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .cfg_n(cfg_n), .dclk(dclk), .data0(data0),
    .status_n(status_n), .conf_done(conf_done), .cfg_done(cfg_done), .cfg_err(cfg_err),
    .err_code(err_code));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit mode_stuck = 0, mode_tout = 0, mode_nocd = 0;
  int ns_fall = 0, ns_rise = 0, dev_bits = 0, exp_bits = 0, trail_cnt = 0;
  int run_len = 0, low_len = 0, last_low = 0, rel_cyc = 0, after_last_ready = 0;
  bit prev_dclk = 0, prev_cfg = 1, last_taken = 0;
  bit capq[$];

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_ge(string tag, int got, int lim);
    checks++;
    if (got < lim) begin
      fails++;
      $display("FAIL %s: got %0d expected >= %0d", tag, got, lim);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!cfg_n) begin
        ns_rise = 0; dev_bits = 0; conf_done = 0; low_len++;
        if (ns_fall < 10) ns_fall++; else status_n = 0;
      end else begin
        ns_fall = 0;
        if (!status_n && !mode_tout) begin
          if (ns_rise < 300) ns_rise++; else status_n = 1;
        end
      end
      if (mode_stuck) status_n = 1;
      if (cfg_n && !prev_cfg) begin last_low = low_len; rel_cyc = cyc; end
      if (!cfg_n && prev_cfg) low_len = 1;
      if (dclk && !prev_dclk) begin
        if (conf_done) trail_cnt++;
        else begin
          capq.push_back(data0); dev_bits++;
          if (dev_bits == exp_bits && !mode_nocd) conf_done = 1;
        end
      end
      if (dclk != prev_dclk) begin
        if (run_len < DIV) chk("R6 dclk phase length", run_len, DIV);
        run_len = 1;
      end else run_len++;
      if (in_ready && dclk) chk("R7 ready while dclk high", 1, 0);
      if (in_ready && last_taken) after_last_ready++;
      prev_dclk = dclk; prev_cfg = cfg_n;
    end
    if (cyc > 150000) begin
      chk("watchdog", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic go();
    capq.delete(); trail_cnt = 0; last_taken = 0; after_last_ready = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic feed(byte unsigned b[], int gap);
    foreach (b[i]) begin
      repeat (gap) @(negedge clk);
      in_valid = 1; in_data = b[i]; in_last = (i == b.size() - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (in_last) last_taken = 1;
      @(negedge clk); in_valid = 0; in_last = 0;
    end
  endtask

  task automatic wait_end();
    while (!cfg_done && !cfg_err) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic chk_bits(byte unsigned b[]);
    chk("R5 bit count", capq.size(), b.size() * 8);
    foreach (b[i]) for (int k = 0; k < 8; k++)
      if (i * 8 + k < capq.size()) chk("R5 LSB-first bit", capq[i*8+k], b[i][k]);
  endtask

  initial begin
    byte unsigned s1[] = '{8'hA5, 8'h3C, 8'h81};
    byte unsigned s2[] = '{8'h01};
    byte unsigned s3[] = '{8'hFE, 8'h7F};
    repeat (4) @(negedge clk);
    chk("R1 cfg_n", cfg_n, 1); chk("R1 dclk", dclk, 0); chk("R1 ready", in_ready, 0);
    chk("R1 done", cfg_done, 0); chk("R1 err", cfg_err, 0);
    rst = 0;
    repeat (4) @(negedge clk);

    exp_bits = 24; go(); feed(s1, 0); wait_end();
    chk_ge("R2 cfg_n low time", last_low, TCFG);
    chk_bits(s1);
    chk("R9 trailing pulses", trail_cnt, 12);
    chk("R9 done", cfg_done, 1); chk("R9 err", cfg_err, 0);
    chk("R7 ready after last", after_last_ready, 0);
    chk("R10 done held cfg_n", cfg_n, 1);

    exp_bits = 8; go(); feed(s2, 7); wait_end();
    chk_bits(s2); chk("R9 trailing pulses b", trail_cnt, 12); chk("R9 done b", cfg_done, 1);

    mode_stuck = 1; go(); wait_end();
    chk("R3 err", cfg_err, 1); chk("R3 code", err_code, 1);
    chk("R10 cfg_n", cfg_n, 1); chk("R10 dclk", dclk, 0);
    chk("R3 no clocks", capq.size(), 0);
    repeat (50) @(negedge clk);
    chk("R10 err held", cfg_err, 1); chk("R10 code held", err_code, 1);
    mode_stuck = 0;

    mode_tout = 1; go(); wait_end();
    chk("R4 err", cfg_err, 1); chk("R4 code", err_code, 2);
    chk_ge("R4 timeout length", cyc - 20 - rel_cyc, TOUT);
    chk("R4 no clocks", capq.size(), 0);
    mode_tout = 0;

    mode_nocd = 1; exp_bits = 16; go();
    chk("R10 err cleared by start", cfg_err, 0);
    feed(s3, 2); wait_end();
    chk("R8 err", cfg_err, 1); chk("R8 code", err_code, 3);
    chk("R8 no trailing pulses", trail_cnt, 0);
    chk_bits(s3); chk("R10 dclk idle", dclk, 0);
    mode_nocd = 0;

    exp_bits = 8; go(); feed(s2, 0); wait_end();
    chk("R10 recover done", cfg_done, 1); chk("R10 recover err", cfg_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule